// File: doc/BRIEF.md
# CEC Receive Address Filter and Acknowledge Policy

This block sits behind the bit sampler of a consumer-electronics control bus receiver. It looks at the header byte of every incoming frame and decides whether the frame belongs to this device. It then holds that decision until the last byte of the frame has had its acknowledge slot. While the frame lasts, the block requests that the bus line be pulled low in each byte's acknowledge slot whenever the acknowledge policy calls for it. When the policy expects an acknowledge and the line stays high, the block raises a missing-acknowledge flag.

The device can claim any number of the fifteen directed logical addresses through a multi-hot mask. A listen-mode input selects between two behaviours. In reduced mode the device takes only its own frames and broadcast frames. In full mode it also snoops frames meant for other devices, but never acknowledges them. Broadcast frames use the opposite acknowledge sense: the device stays passive, and pulls the line low only when the downstream logic asks to refuse the byte.

Top module: `cec_addr_filter`

## Requirements
- R1: After reset, and until a header arrives, frame_accept, ack_drive and miss_ack are all 0.
- R2: Bit k of own_mask (k = 0..14) claims logical address k. A header whose low nibble is k, with bit k set, gives frame_accept = 1 in the cycle after byte_done.
- R3: Several own_mask bits may be set at once. A header matching any one of them is accepted and acknowledged.
- R4: An all-zero own_mask claims no address. In reduced mode (full_listen = 0) a directed header is then not accepted, and no acknowledge is driven for any of its bytes.
- R5: The destination is bits [3:0] of the header and the initiator is bits [7:4]. The initiator value has no effect on acceptance.
- R6: Destination 15 is broadcast. It is accepted whatever own_mask and full_listen hold, and while bcast_nak is 0 ack_drive stays 0 during its acknowledge slots.
- R7: During a broadcast frame, ack_drive is 1 in an acknowledge window only if bcast_nak is 1 in that window.
- R8: With full_listen = 1, a directed frame to an address not in own_mask is accepted and ack_drive stays 0.
- R9: For a frame to an own address, ack_drive is 1 in the acknowledge window of every byte, the header included.
- R10: miss_ack pulses for one cycle, in the cycle after ack_sample, when the frame is accepted, its destination is not broadcast and ack_line is 1. It never pulses in any other case.
- R11: frame_accept holds from the cycle after the header until the cycle after the ack_sample of the byte flagged byte_last, then returns to 0. A byte_done without byte_first while idle starts no frame.
- R12: ack_drive is the acknowledge window delayed by one cycle and qualified by the policy. It is 0 outside an accepted frame and 0 in the cycle after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| own_mask | input | 15 | Claimed logical addresses, one bit per address |
| full_listen | input | 1 | 1 = also accept frames to other destinations, without acknowledging them |
| byte_done | input | 1 | One-cycle strobe: a received byte is complete |
| byte_data | input | 8 | Received byte; for a header, initiator in [7:4] and destination in [3:0] |
| byte_first | input | 1 | Qualifies byte_done: this byte is the header |
| byte_last | input | 1 | Qualifies byte_done: this byte ends the frame |
| ack_window | input | 1 | High during the low-time interval of the acknowledge bit |
| ack_sample | input | 1 | One-cycle strobe at the acknowledge bit sample point |
| ack_line | input | 1 | Bus level sampled with ack_sample |
| bcast_nak | input | 1 | Request to refuse the current broadcast byte |
| frame_accept | output | 1 | Current frame is taken by this device |
| ack_drive | output | 1 | Request to pull the bus line low |
| miss_ack | output | 1 | One-cycle flag: expected acknowledge was not seen |

## Verification
The bench sweeps every destination nibble against single-bit, multi-hot, empty and full masks in both listen modes. This catches a decoder that is off by one in the mask index, or that treats address 15 as a mask bit. Varying the initiator nibble exposes a design that reads the wrong half of the header. Broadcast frames are sent with and without the refuse request, which catches a design that acknowledges broadcasts the same way as directed frames. Frames of one to three bytes show whether acceptance is released at the end of the wrong byte, or whether the header's acknowledge slot is skipped.

// File: rtl/cec_af_pkg.sv
package cec_af_pkg;

    localparam int LA_W    = 4;
    localparam int NUM_LA  = 15;
    localparam int BYTE_W  = 2 * LA_W;

    // Frame ownership classes held while a frame is in progress
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_OWN   = 2'd1,
        FR_BCAST = 2'd2,
        FR_SNOOP = 2'd3
    } frame_cls_e;

    typedef struct packed {
        frame_cls_e cls;
        logic       last_pend;
    } frame_st_t;

    function automatic frame_cls_e classify(input logic is_bcast,
                                            input logic own_hit,
                                            input logic full_mode);
        frame_cls_e c;
        if (is_bcast)       c = FR_BCAST;
        else if (own_hit)   c = FR_OWN;
        else if (full_mode) c = FR_SNOOP;
        else                c = FR_IDLE;
        return c;
    endfunction

    // Frames where a follower is expected to pull the acknowledge low
    function automatic logic is_directed(input frame_cls_e c);
        return (c == FR_OWN) || (c == FR_SNOOP);
    endfunction

    function automatic logic wants_low(input frame_cls_e c, input logic nak);
        return (c == FR_OWN) || ((c == FR_BCAST) && nak);
    endfunction

endpackage

// File: rtl/cec_af_decode.sv
module cec_af_decode
    import cec_af_pkg::*;
#(
    parameter int N_ADDR = NUM_LA,
    parameter int AW     = LA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_ADDR-1:0] own_mask,
    input  logic [AW-1:0]     dest,
    output logic              own_hit,
    output logic              is_bcast
);
    localparam logic [AW-1:0] BCAST_ADDR = {AW{1'b1}};

    logic [N_ADDR-1:0] hit_vec;

    // One comparator per claimable logical address
    for (genvar k = 0; k < N_ADDR; k++) begin : g_match
        if (k == int'(BCAST_ADDR)) begin : g_skip
            assign hit_vec[k] = 1'b0;
        end else begin : g_cmp
            assign hit_vec[k] = own_mask[k] && (dest == AW'(k));
        end
    end

    assign own_hit  = |hit_vec;
    assign is_bcast = (dest == BCAST_ADDR);

    // R4: an empty mask can never claim a destination
    p_empty_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (own_mask == '0) |-> !own_hit);

endmodule

// File: rtl/cec_af_frame_ctl.sv
module cec_af_frame_ctl
    import cec_af_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_done,
    input  logic       byte_first,
    input  logic       byte_last,
    input  logic       ack_sample,
    input  logic       own_hit,
    input  logic       is_bcast,
    input  logic       full_listen,
    output frame_cls_e cls,
    output logic       frame_accept
);
    frame_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (byte_done && byte_first) begin
            st_d.cls       = classify(is_bcast, own_hit, full_listen);
            st_d.last_pend = byte_last;
        end else if (byte_done && (st_q.cls != FR_IDLE)) begin
            st_d.last_pend = byte_last;
        end else if (ack_sample && st_q.last_pend) begin
            st_d.cls       = FR_IDLE;
            st_d.last_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cls       <= FR_IDLE;
            st_q.last_pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cls          = st_q.cls;
    assign frame_accept = (st_q.cls != FR_IDLE);

    // R6: a broadcast header is always taken
    p_bcast_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_done && byte_first && is_bcast) |=> frame_accept);

    // R11: the slot after the final byte releases the frame
    p_release_r11: assert property (@(posedge clk) disable iff (rst)
        (ack_sample && st_q.last_pend && !byte_done) |=> !frame_accept);

    // R11: a non-header byte cannot open a frame
    p_no_open_r11: assert property (@(posedge clk) disable iff (rst)
        (!frame_accept && !(byte_done && byte_first)) |=> !frame_accept);

endmodule

// File: rtl/cec_af_ack.sv
module cec_af_ack
    import cec_af_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_cls_e cls,
    input  logic       ack_window,
    input  logic       ack_sample,
    input  logic       ack_line,
    input  logic       bcast_nak,
    output logic       ack_drive,
    output logic       miss_ack
);
    logic drive_q;
    logic miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= 1'b0;
            miss_q  <= 1'b0;
        end else begin
            drive_q <= ack_window && wants_low(cls, bcast_nak);
            miss_q  <= ack_sample && is_directed(cls) && ack_line;
        end
    end

    assign ack_drive = drive_q;
    assign miss_ack  = miss_q;

    // R12: no drive unless the window was open a cycle earlier
    p_drive_in_window_r12: assert property (@(posedge clk) disable iff (rst)
        ack_drive |-> $past(ack_window));

    // R8: snooped frames are never acknowledged
    p_snoop_silent_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(cls) == FR_SNOOP) |-> !ack_drive);

    // R7: broadcast drive only on a refuse request
    p_bcast_refuse_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_drive && ($past(cls) == FR_BCAST)) |-> $past(bcast_nak));

    // R10: the flag follows a high line at the sample point
    p_miss_cause_r10: assert property (@(posedge clk) disable iff (rst)
        miss_ack |-> ($past(ack_sample) && $past(ack_line)));

endmodule

// File: rtl/cec_addr_filter.sv
module cec_addr_filter
    import cec_af_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_LA-1:0] own_mask,
    input  logic              full_listen,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_first,
    input  logic              byte_last,
    input  logic              ack_window,
    input  logic              ack_sample,
    input  logic              ack_line,
    input  logic              bcast_nak,
    output logic              frame_accept,
    output logic              ack_drive,
    output logic              miss_ack
);
    logic [LA_W-1:0] hdr_dest;
    logic [LA_W-1:0] unused_initiator;
    logic            own_hit;
    logic            is_bcast;
    frame_cls_e      cls;

    assign hdr_dest         = byte_data[LA_W-1:0];
    assign unused_initiator = byte_data[BYTE_W-1:LA_W];

    cec_af_decode #(.N_ADDR(NUM_LA), .AW(LA_W)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .own_mask (own_mask),
        .dest     (hdr_dest),
        .own_hit  (own_hit),
        .is_bcast (is_bcast)
    );

    cec_af_frame_ctl u_frame (
        .clk          (clk),
        .rst          (rst),
        .byte_done    (byte_done),
        .byte_first   (byte_first),
        .byte_last    (byte_last),
        .ack_sample   (ack_sample),
        .own_hit      (own_hit),
        .is_bcast     (is_bcast),
        .full_listen  (full_listen),
        .cls          (cls),
        .frame_accept (frame_accept)
    );

    cec_af_ack u_ack (
        .clk        (clk),
        .rst        (rst),
        .cls        (cls),
        .ack_window (ack_window),
        .ack_sample (ack_sample),
        .ack_line   (ack_line),
        .bcast_nak  (bcast_nak),
        .ack_drive  (ack_drive),
        .miss_ack   (miss_ack)
    );

    // R12: drive never appears outside an accepted frame
    p_drive_in_frame_r12: assert property (@(posedge clk) disable iff (rst)
        ack_drive |-> $past(frame_accept));

endmodule

// File: tb/sim_cec_addr_filter.sv
module sim_cec_addr_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] own_mask = '0;
    logic        full_listen = 1'b0;
    logic        byte_done = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_first = 1'b0;
    logic        byte_last = 1'b0;
    logic        ack_window = 1'b0;
    logic        ack_sample = 1'b0;
    logic        ack_line = 1'b1;
    logic        bcast_nak = 1'b0;
    logic        frame_accept, ack_drive, miss_ack;

    int vectors = 0;
    int miscmp  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cec_addr_filter u0 (
        .clk(clk), .rst(rst), .own_mask(own_mask), .full_listen(full_listen),
        .byte_done(byte_done), .byte_data(byte_data), .byte_first(byte_first),
        .byte_last(byte_last), .ack_window(ack_window), .ack_sample(ack_sample),
        .ack_line(ack_line), .bcast_nak(bcast_nak), .frame_accept(frame_accept),
        .ack_drive(ack_drive), .miss_ack(miss_ack)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Send one frame; the expected values follow from the requirements
    task automatic send_frame(input logic [14:0] mask, input logic full,
                              input logic [3:0] init, input logic [3:0] dest,
                              input int nb, input logic other_ack,
                              input logic nak, input string acc_tag);
        logic bc, own, acc, drv, line;
        string dtag;
        bc  = (dest == 4'hF);
        own = !bc && mask[dest];
        acc = bc || own || full;
        drv = own || (bc && nak);
        dtag = own ? "R9" : (bc ? "R7" : "R8");
        own_mask    = mask;
        full_listen = full;
        bcast_nak   = nak;
        for (int b = 0; b < nb; b++) begin
            byte_done  = 1'b1;
            byte_data  = (b == 0) ? {init, dest} : 8'(b * 37);
            byte_first = (b == 0);
            byte_last  = (b == nb - 1);
            tick();
            byte_done = 1'b0;
            chk(acc_tag, frame_accept, acc);
            ack_window = 1'b1;
            tick();
            chk(dtag, ack_drive, drv);
            tick();
            chk("R12", ack_drive, drv);
            ack_window = 1'b0;
            tick();
            chk("R12", ack_drive, 1'b0);
            line       = !(drv || other_ack);
            ack_sample = 1'b1;
            ack_line   = line;
            tick();
            ack_sample = 1'b0;
            ack_line   = 1'b1;
            chk("R10", miss_ack, acc && !bc && line);
            chk("R11", frame_accept, (b == nb - 1) ? 1'b0 : acc);
            tick();
            chk("R10", miss_ack, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscmp++;
        $display("FAIL watchdog: got running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        logic [14:0] masks [19];
        tick();
        tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        chk("R1", frame_accept, 1'b0);
        chk("R1", ack_drive, 1'b0);
        chk("R1", miss_ack, 1'b0);

        // R11: non-header byte while idle, stray window and sample
        own_mask   = 15'h7FFF;
        byte_done  = 1'b1;
        byte_data  = 8'h03;
        byte_first = 1'b0;
        byte_last  = 1'b1;
        tick();
        byte_done = 1'b0;
        chk("R11", frame_accept, 1'b0);
        ack_window = 1'b1;
        tick();
        ack_window = 1'b0;
        chk("R12", ack_drive, 1'b0);
        ack_sample = 1'b1;
        ack_line   = 1'b1;
        tick();
        ack_sample = 1'b0;
        chk("R10", miss_ack, 1'b0);

        // R5: initiator nibble does not select the destination
        send_frame(15'h0010, 1'b0, 4'h4, 4'h0, 2, 1'b0, 1'b0, "R5");
        send_frame(15'h0010, 1'b0, 4'h0, 4'h4, 2, 1'b0, 1'b0, "R5");
        send_frame(15'h0010, 1'b0, 4'hF, 4'h4, 1, 1'b0, 1'b0, "R5");

        // R6/R7: broadcast with an empty mask in reduced mode
        send_frame(15'h0000, 1'b0, 4'h2, 4'hF, 3, 1'b0, 1'b0, "R6");
        send_frame(15'h0000, 1'b0, 4'h2, 4'hF, 2, 1'b0, 1'b1, "R7");

        for (int k = 0; k < 15; k++) masks[k] = 15'(1 << k);
        masks[15] = 15'h0000;
        masks[16] = 15'h7FFF;
        masks[17] = 15'h5555;
        masks[18] = 15'h2A0C;

        for (int m = 0; m < 19; m++) begin
            for (int f = 0; f < 2; f++) begin
                for (int d = 0; d < 16; d++) begin
                    string tag;
                    if (d == 15)                   tag = "R6";
                    else if (masks[m] == 15'h0)    tag = "R4";
                    else if ($countones(masks[m]) > 1) tag = "R3";
                    else                           tag = "R2";
                    send_frame(masks[m], f[0], 4'(d + m), 4'(d),
                               1 + ((d + m) % 3), 1'((d + m) % 2),
                               1'(d % 2) ^ f[0], tag);
                end
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule